// File: doc/BRIEF.md
# Glitch Motion Monitor

This block watches one output signal as it was sampled, step by step, in two timing corners at once: a fast corner and a slow corner. Each pair of samples is folded into one of four composite states. Equal consecutive states are gathered into runs, and each run is timestamped by a step counter that advances only on accepted samples.

As runs close, the block looks for two kinds of pattern. A full glitch is a difference run that moves across a data run in both corners. A partial glitch shows up in only one corner. For a full glitch, the span over which the pulse can travel is known at both ends. For a partial glitch, the known edge is widened by a programmable estimate. The span is then compared with a required-stable window. Each detection raises a one-cycle event that carries a type code, the span and a violation bit.

A stream is a sequence of samples ended by an end-of-stream strobe. The strobe closes the open run, and after the strobe the next stream starts without any history.

Top module: `glitch_motion_mon`

## Requirements
- R1: The composite state is 0 when both corners read 0, 1 when both read 1, rise (code 2) when the fast corner reads 1 and the slow corner reads 0, and fall (code 3) when the fast corner reads 0 and the slow corner reads 1. A sample is taken only in a cycle where `smp_valid` is high and `stream_end` is low, and only such samples advance the step counter. The first sample after reset is step 0.
- R2: Runs rise, 0, fall in sequence produce type 0 (full, low data). The span starts where the rise run starts and ends where the fall run ends.
- R3: Runs fall, 1, rise in sequence produce type 1 (full, high data). The span starts where the fall run starts and ends where the rise run ends.
- R4: Runs 0, rise, 0 produce type 2, and runs 1, fall, 1 produce type 3. Both are fast-only partials. Each is reported once the run after the trailing data run has started, or once the stream ends. The span is the difference run with its end pushed later by `part_est`, and the end saturates at the largest step value.
- R5: If the run after a fast-only partial is the difference state that completes a full glitch (fall after 0, rise, 0; rise after 1, fall, 1), no partial is reported. The full glitch is reported instead.
- R6: Runs 0, fall, 0 produce type 4, and runs 1, rise, 1 produce type 5. Both are slow-only partials and are reported when the trailing data run closes. The span is the difference run with its start pulled earlier by `part_est`, and the start saturates at 0.
- R7: A slow-only partial is not reported when the run before its leading data run is rise (for 0, fall, 0) or fall (for 1, rise, 1).
- R8: A difference run counts toward at most one reported glitch.
- R9: `evt_hit` is 1 when the span overlaps the window `win_lo`..`win_hi`. Both ends of each range count. The window is taken in the cycle the run closes.
- R10: The event is a one-cycle pulse of `evt_valid`. It appears in the cycle after the sample or `stream_end` that closed the run, and `evt_kind` takes only the codes 0 to 5.
- R11: While reset is low, and in the first cycle after it, `evt_valid` is 0. Reset clears every event output, all run history and the step counter.
- R12: `stream_end` clears all run history, so no pattern joins runs from two streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A sample pair is present this cycle |
| smp_fast | input | 1 | Sample from the fast corner |
| smp_slow | input | 1 | Sample from the slow corner |
| stream_end | input | 1 | Closes the open run and ends the stream; a sample in the same cycle is dropped |
| win_lo | input | TW | First step of the required-stable window |
| win_hi | input | TW | Last step of the required-stable window |
| part_est | input | TW | Movement estimate for partial glitches, in steps |
| evt_valid | output | 1 | One-cycle detection strobe |
| evt_kind | output | 3 | Glitch type code, 0 to 5 |
| evt_lo | output | TW | First step of the motion span |
| evt_hi | output | TW | Last step of the motion span |
| evt_hit | output | 1 | Span overlaps the window |

## Verification
The bench targets the look-ahead case, where 0, rise, 0 is followed by fall. A design that skipped the look-ahead would report a fast-only partial and then the full glitch as well. It also targets the look-back case, where rise precedes 0, fall, 0; a design that skipped it would report an extra slow-only partial. A stream in which a rise run has already been consumed by a full glitch checks that the rise run is not used again for a second one. The window is set exactly on each edge of a span and one step past it, so an off-by-one overlap compare would change `evt_hit`. Saturation is probed with an estimate large enough to wrap, or to go below zero. A design without it would report a span that wraps around. One stream leaves a half-built pattern at its end, and the next stream would complete it if history survived the end strobe.

// File: rtl/gmm_pkg.sv
// Shared encodings for the glitch motion monitor.
// Assumes: two-valued samples only.
package gmm_pkg;

    // Composite state of one time step
    typedef enum logic [1:0] {
        CS_LO   = 2'b00,
        CS_HI   = 2'b01,
        CS_RISE = 2'b10,
        CS_FALL = 2'b11
    } comp_e;

    // Reported glitch type
    typedef enum logic [2:0] {
        GK_FULL_LO  = 3'd0,
        GK_FULL_HI  = 3'd1,
        GK_FAST_LO  = 3'd2,
        GK_FAST_HI  = 3'd3,
        GK_SLOW_LO  = 3'd4,
        GK_SLOW_HI  = 3'd5
    } kind_e;

    // Fold the fast and slow samples into one composite code
    function automatic logic [1:0] merge_corners(input logic fast, input logic slow);
        logic differ;
        differ = fast ^ slow;
        return {differ, differ ? slow : fast};
    endfunction

endpackage

// File: rtl/gmm_run_tracker.sv
// Run tracker: timestamps accepted samples, keeps the open run and the
// three most recent closed runs, and shifts history when a run closes.
// Assumes: stream_end drops any sample presented in the same cycle.
module gmm_run_tracker
    import gmm_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic          smp_fast,
    input  logic          smp_slow,
    input  logic          stream_end,
    input  logic          mark_r0,
    input  logic          mark_r1,
    output logic          close_ev,
    output logic          nxt_known,
    output logic [1:0]    nxt_st,
    output logic [1:0]    op_st,
    output logic [TW-1:0] op_last,
    output logic          r1_vld,
    output logic [1:0]    r1_st,
    output logic [TW-1:0] r1_first,
    output logic [TW-1:0] r1_last,
    output logic          r1_used,
    output logic          r2_vld,
    output logic [1:0]    r2_st,
    output logic [TW-1:0] r2_first,
    output logic          r2_used,
    output logic          r3_vld,
    output logic [1:0]    r3_st
);

    logic [TW-1:0] t_now;
    logic          op_vld;
    logic [TW-1:0] op_first;
    logic [1:0]    comp;
    logic          take;
    logic          changed;

    // Classify the incoming sample and decide whether a run closes
    always_comb begin
        comp      = merge_corners(smp_fast, smp_slow);
        take      = smp_valid && !stream_end;
        changed   = op_vld && (comp != op_st);
        close_ev  = op_vld && (stream_end || (take && changed));
        nxt_known = take;
        nxt_st    = comp;
    end

    // Step counter advancing once per accepted sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_now <= '0;
        end else if (take) begin
            t_now <= t_now + TW'(1);
        end
    end

    // Open run: start a new one on a state change, else extend it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_vld   <= 1'b0;
            op_st    <= CS_LO;
            op_first <= '0;
            op_last  <= '0;
        end else if (stream_end) begin
            op_vld <= 1'b0;
        end else if (take) begin
            if (!op_vld || changed) begin
                op_vld   <= 1'b1;
                op_st    <= comp;
                op_first <= t_now;
            end
            op_last <= t_now;
        end
    end

    // Closed-run history: shift on close, wipe at end of stream
    always_ff @(posedge clk) begin
        if (!rst_n || stream_end) begin
            r1_vld   <= 1'b0;
            r1_st    <= CS_LO;
            r1_first <= '0;
            r1_last  <= '0;
            r1_used  <= 1'b0;
            r2_vld   <= 1'b0;
            r2_st    <= CS_LO;
            r2_first <= '0;
            r2_used  <= 1'b0;
            r3_vld   <= 1'b0;
            r3_st    <= CS_LO;
        end else if (close_ev) begin
            r3_vld   <= r2_vld;
            r3_st    <= r2_st;
            r2_vld   <= r1_vld;
            r2_st    <= r1_st;
            r2_first <= r1_first;
            r2_used  <= r1_used | mark_r1;
            r1_vld   <= 1'b1;
            r1_st    <= op_st;
            r1_first <= op_first;
            r1_last  <= op_last;
            r1_used  <= mark_r0;
        end
    end

endmodule

// File: rtl/gmm_pattern_match.sv
// Pattern matcher: on each run close, tests the closing run and the
// history for full and partial glitch sequences and computes the span.
// Assumes: at most one pattern can match a given close.
module gmm_pattern_match
    import gmm_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          close_ev,
    input  logic          nxt_known,
    input  logic [1:0]    nxt_st,
    input  logic [1:0]    op_st,
    input  logic [TW-1:0] op_last,
    input  logic          r1_vld,
    input  logic [1:0]    r1_st,
    input  logic [TW-1:0] r1_first,
    input  logic [TW-1:0] r1_last,
    input  logic          r1_used,
    input  logic          r2_vld,
    input  logic [1:0]    r2_st,
    input  logic [TW-1:0] r2_first,
    input  logic          r2_used,
    input  logic          r3_vld,
    input  logic [1:0]    r3_st,
    input  logic [TW-1:0] part_est,
    output logic          match,
    output logic [2:0]    kind,
    output logic [TW-1:0] sp_lo,
    output logic [TW-1:0] sp_hi,
    output logic          mark_r0,
    output logic          mark_r1
);

    // Add with clamp at the top step value
    function automatic logic [TW-1:0] add_sat(input logic [TW-1:0] a, input logic [TW-1:0] b);
        logic [TW:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[TW] ? {TW{1'b1}} : s[TW-1:0];
    endfunction

    // Subtract with clamp at step 0
    function automatic logic [TW-1:0] sub_sat(input logic [TW-1:0] a, input logic [TW-1:0] b);
        return (a < b) ? '0 : a - b;
    endfunction

    logic three;
    logic full_lo, full_hi, fast_lo, fast_hi, slow_lo, slow_hi;

    // Sequence tests over the last three runs
    always_comb begin
        three   = close_ev && r1_vld && r2_vld;
        full_lo = three && r2_st == CS_RISE && r1_st == CS_LO && op_st == CS_FALL && !r2_used;
        full_hi = three && r2_st == CS_FALL && r1_st == CS_HI && op_st == CS_RISE && !r2_used;
        fast_lo = three && r2_st == CS_LO && r1_st == CS_RISE && op_st == CS_LO && !r1_used
                  && !(nxt_known && nxt_st == CS_FALL);
        fast_hi = three && r2_st == CS_HI && r1_st == CS_FALL && op_st == CS_HI && !r1_used
                  && !(nxt_known && nxt_st == CS_RISE);
        slow_lo = three && r2_st == CS_LO && r1_st == CS_FALL && op_st == CS_LO && !r1_used
                  && !(r3_vld && r3_st == CS_RISE);
        slow_hi = three && r2_st == CS_HI && r1_st == CS_RISE && op_st == CS_HI && !r1_used
                  && !(r3_vld && r3_st == CS_FALL);
    end

    // Type code, span and ownership marks for the matched pattern
    always_comb begin
        match   = full_lo | full_hi | fast_lo | fast_hi | slow_lo | slow_hi;
        mark_r0 = full_lo | full_hi;
        mark_r1 = fast_lo | fast_hi | slow_lo | slow_hi;
        kind    = GK_FULL_LO;
        sp_lo   = r1_first;
        sp_hi   = r1_last;
        if (full_lo || full_hi) begin
            kind  = full_lo ? GK_FULL_LO : GK_FULL_HI;
            sp_lo = r2_first;
            sp_hi = op_last;
        end else if (fast_lo || fast_hi) begin
            kind  = fast_lo ? GK_FAST_LO : GK_FAST_HI;
            sp_hi = add_sat(r1_last, part_est);
        end else if (slow_lo || slow_hi) begin
            kind  = slow_lo ? GK_SLOW_LO : GK_SLOW_HI;
            sp_lo = sub_sat(r1_first, part_est);
        end
    end

endmodule

// File: rtl/gmm_event_reg.sv
// Event stage: registers a detection, compares its span with the
// stability window and drives the one-cycle strobe.
// Assumes: window bounds are stable in the cycle a run closes.
module gmm_event_reg #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          match,
    input  logic [2:0]    kind,
    input  logic [TW-1:0] sp_lo,
    input  logic [TW-1:0] sp_hi,
    input  logic [TW-1:0] win_lo,
    input  logic [TW-1:0] win_hi,
    output logic          evt_valid,
    output logic [2:0]    evt_kind,
    output logic [TW-1:0] evt_lo,
    output logic [TW-1:0] evt_hi,
    output logic          evt_hit
);

    logic overlap;

    // Inclusive overlap of span and window
    always_comb begin
        overlap = (sp_lo <= win_hi) && (sp_hi >= win_lo);
    end

    // Capture the detection and pulse the strobe for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_kind  <= '0;
            evt_lo    <= '0;
            evt_hi    <= '0;
            evt_hit   <= 1'b0;
        end else begin
            evt_valid <= match;
            if (match) begin
                evt_kind <= kind;
                evt_lo   <= sp_lo;
                evt_hi   <= sp_hi;
                evt_hit  <= overlap;
            end
        end
    end

endmodule

// File: rtl/glitch_motion_mon.sv
// Top: streaming glitch motion monitor over fast/slow corner samples.
// Assumes: one signal, two-valued samples, one sample per cycle at most.
module glitch_motion_mon #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic          smp_fast,
    input  logic          smp_slow,
    input  logic          stream_end,
    input  logic [TW-1:0] win_lo,
    input  logic [TW-1:0] win_hi,
    input  logic [TW-1:0] part_est,
    output logic          evt_valid,
    output logic [2:0]    evt_kind,
    output logic [TW-1:0] evt_lo,
    output logic [TW-1:0] evt_hi,
    output logic          evt_hit
);

    logic          close_ev, nxt_known, mark_r0, mark_r1, match;
    logic [1:0]    nxt_st, op_st, r1_st, r2_st, r3_st;
    logic [TW-1:0] op_last, r1_first, r1_last, r2_first, sp_lo, sp_hi;
    logic          r1_vld, r1_used, r2_vld, r2_used, r3_vld;
    logic [2:0]    kind;

    gmm_run_tracker #(.TW(TW)) u_trk (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_fast(smp_fast),
        .smp_slow(smp_slow), .stream_end(stream_end), .mark_r0(mark_r0),
        .mark_r1(mark_r1), .close_ev(close_ev), .nxt_known(nxt_known),
        .nxt_st(nxt_st), .op_st(op_st), .op_last(op_last), .r1_vld(r1_vld),
        .r1_st(r1_st), .r1_first(r1_first), .r1_last(r1_last), .r1_used(r1_used),
        .r2_vld(r2_vld), .r2_st(r2_st), .r2_first(r2_first), .r2_used(r2_used),
        .r3_vld(r3_vld), .r3_st(r3_st)
    );

    gmm_pattern_match #(.TW(TW)) u_pm (
        .close_ev(close_ev), .nxt_known(nxt_known), .nxt_st(nxt_st),
        .op_st(op_st), .op_last(op_last), .r1_vld(r1_vld), .r1_st(r1_st),
        .r1_first(r1_first), .r1_last(r1_last), .r1_used(r1_used),
        .r2_vld(r2_vld), .r2_st(r2_st), .r2_first(r2_first), .r2_used(r2_used),
        .r3_vld(r3_vld), .r3_st(r3_st), .part_est(part_est), .match(match),
        .kind(kind), .sp_lo(sp_lo), .sp_hi(sp_hi), .mark_r0(mark_r0),
        .mark_r1(mark_r1)
    );

    gmm_event_reg #(.TW(TW)) u_ev (
        .clk(clk), .rst_n(rst_n), .match(match), .kind(kind), .sp_lo(sp_lo),
        .sp_hi(sp_hi), .win_lo(win_lo), .win_hi(win_hi), .evt_valid(evt_valid),
        .evt_kind(evt_kind), .evt_lo(evt_lo), .evt_hi(evt_hi), .evt_hit(evt_hit)
    );

endmodule

// File: rtl/gmm_checker.sv
// Checker: port-level properties of the glitch motion monitor, bound
// to the top module.
// Assumes: synchronous active-low reset.
module gmm_checker #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic          stream_end,
    input logic [TW-1:0] win_lo,
    input logic [TW-1:0] win_hi,
    input logic          evt_valid,
    input logic [2:0]    evt_kind,
    input logic [TW-1:0] evt_lo,
    input logic [TW-1:0] evt_hi,
    input logic          evt_hit
);

    // R11
    rst_quiet_chk: assert property (@(posedge clk) !rst_n |=> !evt_valid);

    // R10
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(smp_valid || stream_end));

    // R10
    kind_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> evt_kind <= 3'd5);

    // R4
    span_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> evt_lo <= evt_hi);

    // R9
    miss_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_hi < $past(win_lo)) |-> !evt_hit);

    // R9
    miss_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_lo > $past(win_hi)) |-> !evt_hit);

    // R2
    full_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 3'd0) |-> (evt_hi - evt_lo) >= TW'(2));

endmodule

bind glitch_motion_mon gmm_checker #(.TW(TW)) u_gmm_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .stream_end(stream_end),
    .win_lo(win_lo), .win_hi(win_hi), .evt_valid(evt_valid),
    .evt_kind(evt_kind), .evt_lo(evt_lo), .evt_hi(evt_hi), .evt_hit(evt_hit)
);

// File: tb/tb_glitch_motion_mon.sv
// Scoreboard bench: scenario tasks queue the hand-computed events,
// a monitor pops and compares them as the design reports them.
module tb_glitch_motion_mon;

    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0, smp_fast = 1'b0, smp_slow = 1'b0, stream_end = 1'b0;
    logic [TW-1:0] win_lo = '0, win_hi = '0, part_est = '0;
    logic          evt_valid, evt_hit;
    logic [2:0]    evt_kind;
    logic [TW-1:0] evt_lo, evt_hi;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R11";

    logic [2:0]    q_kind[$];
    logic [TW-1:0] q_lo[$];
    logic [TW-1:0] q_hi[$];
    logic          q_hit[$];
    string         q_req[$];

    always #2 clk = ~clk;

    glitch_motion_mon #(.TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_fast(smp_fast),
        .smp_slow(smp_slow), .stream_end(stream_end), .win_lo(win_lo),
        .win_hi(win_hi), .part_est(part_est), .evt_valid(evt_valid),
        .evt_kind(evt_kind), .evt_lo(evt_lo), .evt_hi(evt_hi), .evt_hit(evt_hit)
    );

    task automatic tick_in(input logic v, input logic f, input logic s, input logic e);
        @(negedge clk);
        smp_valid = v; smp_fast = f; smp_slow = s; stream_end = e;
    endtask

    // state codes: 0 low, 1 high, 2 rise (fast 1 slow 0), 3 fall (fast 0 slow 1)
    task automatic send_run(input int st, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            case (st)
                0: tick_in(1'b1, 1'b0, 1'b0, 1'b0);
                1: tick_in(1'b1, 1'b1, 1'b1, 1'b0);
                2: tick_in(1'b1, 1'b1, 1'b0, 1'b0);
                default: tick_in(1'b1, 1'b0, 1'b1, 1'b0);
            endcase
            for (int g = 0; g < gap; g++) tick_in(1'b0, 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic push(input logic [2:0] k, input int lo, input int hi, input logic h, input string r);
        q_kind.push_back(k); q_lo.push_back(TW'(lo)); q_hi.push_back(TW'(hi));
        q_hit.push_back(h); q_req.push_back(r);
    endtask

    task automatic start(input string r, input int wl, input int wh, input int est);
        cur_req = r;
        tick_in(1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        repeat (2) tick_in(1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        win_lo = TW'(wl); win_hi = TW'(wh); part_est = TW'(est);
    endtask

    task automatic finish_stream();
        tick_in(1'b0, 1'b0, 1'b0, 1'b1);
        repeat (4) tick_in(1'b0, 1'b0, 1'b0, 1'b0);
        n_chk++;
        if (q_kind.size() != 0) begin
            n_bad++;
            $display("FAIL %s missing events actual=0 expected=%0d", q_req[0], q_kind.size());
            q_kind.delete(); q_lo.delete(); q_hi.delete(); q_hit.delete(); q_req.delete();
        end
    endtask

    task automatic check_bit(input string r, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s evt_valid actual=%0b expected=%0b", r, act, exp);
        end
    endtask

    // Monitor: compare each reported event with the queue head
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && evt_valid) begin
                n_chk++;
                if (q_kind.size() == 0) begin
                    n_bad++;
                    $display("FAIL %s unexpected event actual=kind%0d %0d..%0d expected=none",
                             cur_req, evt_kind, evt_lo, evt_hi);
                end else begin
                    if (evt_kind !== q_kind[0] || evt_lo !== q_lo[0] || evt_hi !== q_hi[0]
                        || evt_hit !== q_hit[0]) begin
                        n_bad++;
                        $display("FAIL %s actual=kind%0d %0d..%0d hit%0b expected=kind%0d %0d..%0d hit%0b",
                                 q_req[0], evt_kind, evt_lo, evt_hi, evt_hit,
                                 q_kind[0], q_lo[0], q_hi[0], q_hit[0]);
                    end
                    void'(q_kind.pop_front()); void'(q_lo.pop_front()); void'(q_hi.pop_front());
                    void'(q_hit.pop_front()); void'(q_req.pop_front());
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    task automatic stream_full_lo(input string r, input int wl, input int wh, input logic h);
        start(r, wl, wh, 0);
        push(3'd0, 20, 50, h, r);
        send_run(0, 20, 0); send_run(2, 5, 0); send_run(0, 20, 0);
        send_run(3, 6, 0); send_run(0, 5, 0);
        finish_stream();
    endtask

    initial begin
        start("R11", 0, 0, 0);
        // R11 reset values on every event output
        n_chk++;
        if (evt_valid !== 1'b0 || evt_hit !== 1'b0 || evt_kind !== 3'd0 || evt_lo !== '0 || evt_hi !== '0) begin
            n_bad++;
            $display("FAIL R11 actual=%0b%0b k%0d %0d..%0d expected=all zero",
                     evt_valid, evt_hit, evt_kind, evt_lo, evt_hi);
        end

        // R2 R5 R1: full low with the look-ahead suppressing 0-rise-0
        stream_full_lo("R2", 33, 43, 1'b1);
        // R9 window edges against span 20..50
        stream_full_lo("R9", 50, 60, 1'b1);
        stream_full_lo("R9", 51, 60, 1'b0);
        stream_full_lo("R9", 10, 19, 1'b0);
        stream_full_lo("R9", 10, 20, 1'b1);

        // R3 full high; trailing 1 cannot reuse the rise run (R8)
        start("R3", 13, 20, 0);
        push(3'd1, 5, 13, 1'b1, "R3");
        send_run(1, 5, 0); send_run(3, 3, 0); send_run(1, 4, 0);
        send_run(2, 2, 0); send_run(1, 3, 0);
        finish_stream();

        // R4 R1 fast-only low closed by stream end, idle gaps between samples
        start("R4", 8, 9, 3);
        push(3'd2, 4, 8, 1'b1, "R4");
        send_run(0, 4, 2); send_run(2, 2, 1); send_run(0, 3, 3);
        finish_stream();

        // R4 R10 fast-only low closed by the next run, with event timing
        start("R10", 6, 9, 0);
        push(3'd2, 4, 5, 1'b0, "R4");
        send_run(0, 4, 0); send_run(2, 2, 0); send_run(0, 3, 0);
        tick_in(1'b1, 1'b1, 1'b1, 1'b0);
        tick_in(1'b0, 1'b0, 1'b0, 1'b0);
        check_bit("R10", evt_valid, 1'b1);
        tick_in(1'b0, 1'b0, 1'b0, 1'b0);
        check_bit("R10", evt_valid, 1'b0);
        send_run(1, 1, 0);
        finish_stream();

        // R4 fast-only high
        start("R4", 7, 9, 2);
        push(3'd3, 3, 6, 1'b0, "R4");
        send_run(1, 3, 0); send_run(3, 2, 0); send_run(1, 2, 0); send_run(0, 1, 0);
        finish_stream();

        // R6 slow-only low, start saturates at 0
        start("R6", 0, 0, 5);
        push(3'd4, 0, 6, 1'b1, "R6");
        send_run(0, 3, 0); send_run(3, 4, 0); send_run(0, 2, 0);
        finish_stream();

        // R6 slow-only high with an unrelated run in front
        start("R6", 2, 3, 1);
        push(3'd5, 3, 5, 1'b1, "R6");
        send_run(0, 2, 0); send_run(1, 2, 0); send_run(2, 2, 0);
        send_run(1, 2, 0); send_run(0, 1, 0);
        finish_stream();

        // R7 R8: rise used by full high, not reused; look-back blocks 0-fall-0
        start("R8", 100, 200, 0);
        push(3'd1, 0, 5, 1'b0, "R8");
        send_run(3, 2, 0); send_run(1, 2, 0); send_run(2, 2, 0);
        send_run(0, 2, 0); send_run(3, 2, 0); send_run(0, 2, 0);
        finish_stream();

        // R5 full low closed by stream end
        start("R5", 0, 1, 0);
        push(3'd0, 2, 5, 1'b0, "R5");
        send_run(0, 2, 0); send_run(2, 1, 0); send_run(0, 2, 0); send_run(3, 1, 0);
        finish_stream();

        // R12 half pattern must not join the next stream
        start("R12", 0, 100, 0);
        send_run(0, 2, 0); send_run(2, 2, 0);
        finish_stream();
        send_run(0, 2, 0); send_run(1, 1, 0);
        finish_stream();

        // R4 end of span saturates at the top step value
        start("R4", 16'hFFF0, 16'hFFFF, 16'hFFFF);
        push(3'd2, 1, 16'hFFFF, 1'b1, "R4");
        send_run(0, 1, 0); send_run(2, 1, 0); send_run(0, 1, 0);
        finish_stream();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule